// File: doc/BRIEF.md
# Row Control Packet Decoder

This block receives the three-wire row control bus of a packet-driven memory device and turns it into command strobes. The bus carries two bit-times per clock (one on each clock edge), delivered to the block as an early and a late 3-bit slice per cycle. Eight bit-times, or four cycles, form one 24-bit packet. The decoder looks for a frame, collects the packet, and checks the device address against a 5-bit device number supplied from outside. It then decodes either an activate packet, which carries a bank and a 9-bit row, or a row-operation packet, which carries an 11-bit opcode.

The opcode may hold several commands at once. For example, a precharge can travel together with a power request and a relax request in a single packet. The block also keeps the refresh row counter. A refresh-activate command reads the counter as its row address, and the counter steps forward after a refresh-activate to the highest bank. The power-state machine, the signalling and the clock recovery are outside this block: it only raises the request strobes.

Top module: `row_packet_decoder`

## Requirements
- R1: A frame starts only in a cycle whose early bit-time has wire 2 or wire 1 set, and only while no packet is being collected. The other seven bit-times of a packet are never examined for a frame. A late-only pulse, or a first bit-time with wires 2 and 1 both clear, starts nothing. Packets may follow one another with no idle cycle between them.
- R2: Each strobe is high for exactly one cycle: the cycle after the clock edge that samples the packet's fourth cycle.
- R3: Wire 2 and wire 1 of the first bit-time form a code {w2,w1}. Code 11 is broadcast and always matches. Code 01 matches when dev_id == {0,d3..d0}. Code 10 matches when dev_id == {1,d3..d0}. The address bits sit as follows: d3 on wire 0 at bit-time 0; d2, d1 and d0 on wires 2, 1 and 0 at bit-time 1. A packet that does not match raises no strobe.
- R4: When wire 0 at bit-time 4 is 1, the packet is an activate. act_stb rises, and cmd_bank and cmd_row take the bank and row fields. The bank bits sit as follows: bank bits 0, 1 and 2 on wires 2, 1 and 0 at bit-time 2; bank bits 3 and 4 on wires 2 and 1 at bit-time 3. The row bits run from bit 8 down to bit 0 over bit-times 5, 6 and 7, taking wires 2, 1 and 0 in turn at each bit-time.
- R5: When wire 0 at bit-time 4 is 0, the opcode bits are placed as follows. Bits 10 and 9 are wires 2 and 1 at bit-time 4. Bits 8 down to 0 use the same positions as the row bits. Opcode bits 10..6 = 11000 with bits 2..0 = 000 raise pre_stb.
- R6: Opcode bits 10..4 = 0001100 with bits 2..0 = 000 raise refa_stb, and cmd_row then shows the refresh counter. The counter resets to REFR_RESET and wraps at 9 bits. It advances by one only after a refresh-activate to bank 31.
- R7: Opcode bits 10..4 = 1010100 with bits 2..0 = 000 raise refp_stb.
- R8: When bits 2..0 = 000, opcode bits 8..4 select a power request: 00001 raises pdn_req, 00010 raises nap_req and 00011 raises napc_req. These can be combined with a precharge in the same packet.
- R9: When bits 2..0 = 000, bit 3 = 1 raises rlx_req. Bit 3 = 0 with bits 10..4 not all zero raises attn_req, and so does a matched activate. A broadcast packet never raises attn_req.
- R10: When bits 10..3 are all zero, bits 2..0 = 001 raise tcal_stb and 010 raise tcen_stb. An all-zero opcode, and any other low code, raises nothing.
- R11: After reset all strobes are low, and cmd_bank and cmd_row are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; each cycle carries two bit-times |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_id | input | 5 | Device number this decoder answers to |
| row_early | input | 3 | Bus wires 2..0 for the first bit-time of the cycle |
| row_late | input | 3 | Bus wires 2..0 for the second bit-time of the cycle |
| act_stb | output | 1 | Activate strobe |
| pre_stb | output | 1 | Precharge strobe |
| refa_stb | output | 1 | Refresh-activate strobe |
| refp_stb | output | 1 | Refresh-precharge strobe |
| pdn_req | output | 1 | Power-down request |
| nap_req | output | 1 | Nap request |
| napc_req | output | 1 | Conditional nap request |
| rlx_req | output | 1 | Relax (standby) request |
| attn_req | output | 1 | Attention request |
| tcal_stb | output | 1 | Temperature calibrate strobe |
| tcen_stb | output | 1 | Temperature calibrate-enable strobe |
| cmd_bank | output | 5 | Bank of the last matched packet |
| cmd_row | output | 9 | Row of the last activate or refresh-activate |

## Verification
The bench builds the decoder with REFR_RESET set to 9'h1FE. This puts the 9-bit wrap of the refresh counter only two bank-31 refreshes away, so the bench checks the step from 1FF to 000 directly instead of issuing hundreds of refreshes. The device number is held at 5'h0A, which lets a single address nibble show both a match under code 01 and a miss under code 10. Opcodes that combine several commands are sent, along with back-to-back packets and broadcast packets.

// File: rtl/row_pkt_pkg.sv
package row_pkt_pkg;
  localparam int WIRES      = 3;
  localparam int BT_PER_CYC = 2;
  localparam int PKT_BT     = 8;
  localparam int PKT_CYC    = PKT_BT / BT_PER_CYC;
  localparam int PKT_BITS   = WIRES * PKT_BT;
  localparam int SLICE_W    = WIRES * BT_PER_CYC;
  localparam int DEV_W      = 5;
  localparam int BANK_W     = 5;
  localparam int ROW_W      = 9;
  localparam int ROP_W      = 11;

  localparam int WA = 2;
  localparam int WB = 1;
  localparam int WC = 0;

  localparam logic [4:0] OPH_PRE  = 5'b11000;
  localparam logic [6:0] OPH_REFA = 7'b0001100;
  localparam logic [6:0] OPH_REFP = 7'b1010100;
  localparam logic [4:0] PWR_PDN  = 5'b00001;
  localparam logic [4:0] PWR_NAP  = 5'b00010;
  localparam logic [4:0] PWR_NAPC = 5'b00011;
  localparam logic [2:0] LOW_TCAL = 3'b001;
  localparam logic [2:0] LOW_TCEN = 3'b010;

  typedef struct packed {
    logic act;
    logic pre;
    logic refa;
    logic refp;
    logic pdn;
    logic nap;
    logic napc;
    logic rlx;
    logic attn;
    logic tcal;
    logic tcen;
  } row_cmd_t;

  function automatic logic bt(input logic [PKT_BITS-1:0] p, input int t, input int w);
    return p[t*WIRES + w];
  endfunction

  function automatic logic [1:0] pkt_code(input logic [PKT_BITS-1:0] p);
    return {bt(p, 0, WA), bt(p, 0, WB)};
  endfunction

  function automatic logic [DEV_W-2:0] pkt_dev_low(input logic [PKT_BITS-1:0] p);
    return {bt(p, 0, WC), bt(p, 1, WA), bt(p, 1, WB), bt(p, 1, WC)};
  endfunction

  function automatic logic [BANK_W-1:0] pkt_bank(input logic [PKT_BITS-1:0] p);
    return {bt(p, 3, WB), bt(p, 3, WA), bt(p, 2, WC), bt(p, 2, WB), bt(p, 2, WA)};
  endfunction

  function automatic logic pkt_av(input logic [PKT_BITS-1:0] p);
    return bt(p, 4, WC);
  endfunction

  function automatic logic [ROW_W-1:0] pkt_row(input logic [PKT_BITS-1:0] p);
    return {bt(p, 5, WA), bt(p, 5, WB), bt(p, 5, WC),
            bt(p, 6, WA), bt(p, 6, WB), bt(p, 6, WC),
            bt(p, 7, WA), bt(p, 7, WB), bt(p, 7, WC)};
  endfunction

  function automatic logic [ROP_W-1:0] pkt_rop(input logic [PKT_BITS-1:0] p);
    return {bt(p, 4, WA), bt(p, 4, WB), pkt_row(p)};
  endfunction
endpackage

// File: rtl/row_deframer.sv
module row_deframer
  import row_pkt_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [WIRES-1:0]    row_early,
  input  logic [WIRES-1:0]    row_late,
  output logic                pkt_done,
  output logic [PKT_BITS-1:0] pkt
);
  localparam int CNT_W  = $clog2(PKT_CYC);
  localparam int HOLD_W = PKT_BITS - SLICE_W;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PKT_CYC - 1);

  logic              busy;
  logic [CNT_W-1:0]  cnt;
  logic [HOLD_W-1:0] hold;
  logic              frame_start;

  assign frame_start = !busy && (row_early[WA] || row_early[WB]);
  assign pkt_done    = busy && (cnt == LAST);
  assign pkt         = {row_late, row_early, hold};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
      hold <= '0;
    end else if (frame_start) begin
      hold[SLICE_W-1:0] <= {row_late, row_early};
      cnt  <= CNT_W'(1);
      busy <= 1'b1;
    end else if (busy) begin
      if (cnt == LAST) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else begin
        hold[cnt*SLICE_W +: SLICE_W] <= {row_late, row_early};
        cnt <= cnt + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/row_dev_match.sv
module row_dev_match
  import row_pkt_pkg::*;
(
  input  logic [1:0]       code,
  input  logic [DEV_W-2:0] dev_low,
  input  logic [DEV_W-1:0] dev_id,
  output logic             hit,
  output logic             bcast
);
  always_comb begin
    hit   = 1'b0;
    bcast = 1'b0;
    unique case (code)
      2'b11: begin hit = 1'b1; bcast = 1'b1; end
      2'b01: hit = (dev_id == {1'b0, dev_low});
      2'b10: hit = (dev_id == {1'b1, dev_low});
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/row_op_decode.sv
module row_op_decode
  import row_pkt_pkg::*;
(
  input  logic             vld,
  input  logic             hit,
  input  logic             bcast,
  input  logic             av,
  input  logic [ROP_W-1:0] rop,
  output row_cmd_t         cmd
);
  logic op_ok, low_zero;

  assign op_ok    = vld && hit && !av;
  assign low_zero = (rop[2:0] == 3'b000);

  always_comb begin
    cmd      = '0;
    cmd.act  = vld && hit && av;
    cmd.pre  = op_ok && low_zero && (rop[10:6] == OPH_PRE);
    cmd.refa = op_ok && low_zero && (rop[10:4] == OPH_REFA);
    cmd.refp = op_ok && low_zero && (rop[10:4] == OPH_REFP);
    cmd.pdn  = op_ok && low_zero && (rop[8:4] == PWR_PDN);
    cmd.nap  = op_ok && low_zero && (rop[8:4] == PWR_NAP);
    cmd.napc = op_ok && low_zero && (rop[8:4] == PWR_NAPC);
    cmd.rlx  = op_ok && low_zero && rop[3];
    cmd.attn = !bcast && ((op_ok && low_zero && !rop[3] && (rop[10:4] != '0)) || cmd.act);
    cmd.tcal = op_ok && (rop[10:3] == '0) && (rop[2:0] == LOW_TCAL);
    cmd.tcen = op_ok && (rop[10:3] == '0) && (rop[2:0] == LOW_TCEN);
  end
endmodule

// File: rtl/row_refresh_counter.sv
module row_refresh_counter #(
  parameter int          W    = 9,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bump,
  output logic [W-1:0] cur
);
  always_ff @(posedge clk) begin
    if (!rst_n)    cur <= INIT;
    else if (bump) cur <= cur + W'(1);
  end
endmodule

// File: rtl/row_packet_decoder.sv
module row_packet_decoder
  import row_pkt_pkg::*;
#(
  parameter logic [8:0] REFR_RESET = 9'h000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [4:0] dev_id,
  input  logic [2:0] row_early,
  input  logic [2:0] row_late,
  output logic       act_stb,
  output logic       pre_stb,
  output logic       refa_stb,
  output logic       refp_stb,
  output logic       pdn_req,
  output logic       nap_req,
  output logic       napc_req,
  output logic       rlx_req,
  output logic       attn_req,
  output logic       tcal_stb,
  output logic       tcen_stb,
  output logic [4:0] cmd_bank,
  output logic [8:0] cmd_row
);
  localparam logic [BANK_W-1:0] TOP_BANK = '1;

  logic [PKT_BITS-1:0] pkt;
  logic                pkt_done;
  logic                dev_hit, dev_bcast;
  logic [BANK_W-1:0]   pkt_bank_w;
  row_cmd_t            cmd_next, cmd_q;
  logic                refr_bump;
  logic [ROW_W-1:0]    refr_cnt;
  logic                unused_rsv;

  assign unused_rsv = pkt[3*WIRES + WC];
  assign pkt_bank_w = pkt_bank(pkt);

  row_deframer u_deframe (
    .clk(clk), .rst_n(rst_n), .row_early(row_early), .row_late(row_late),
    .pkt_done(pkt_done), .pkt(pkt)
  );

  row_dev_match u_match (
    .code(pkt_code(pkt)), .dev_low(pkt_dev_low(pkt)), .dev_id(dev_id),
    .hit(dev_hit), .bcast(dev_bcast)
  );

  row_op_decode u_dec (
    .vld(pkt_done), .hit(dev_hit), .bcast(dev_bcast), .av(pkt_av(pkt)),
    .rop(pkt_rop(pkt)), .cmd(cmd_next)
  );

  assign refr_bump = cmd_next.refa && (pkt_bank_w == TOP_BANK);

  row_refresh_counter #(.W(ROW_W), .INIT(REFR_RESET)) u_refr (
    .clk(clk), .rst_n(rst_n), .bump(refr_bump), .cur(refr_cnt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q    <= '0;
      cmd_bank <= '0;
      cmd_row  <= '0;
    end else begin
      cmd_q <= cmd_next;
      if (pkt_done && dev_hit) cmd_bank <= pkt_bank_w;
      if (cmd_next.act)        cmd_row  <= pkt_row(pkt);
      else if (cmd_next.refa)  cmd_row  <= refr_cnt;
    end
  end

  assign act_stb  = cmd_q.act;
  assign pre_stb  = cmd_q.pre;
  assign refa_stb = cmd_q.refa;
  assign refp_stb = cmd_q.refp;
  assign pdn_req  = cmd_q.pdn;
  assign nap_req  = cmd_q.nap;
  assign napc_req = cmd_q.napc;
  assign rlx_req  = cmd_q.rlx;
  assign attn_req = cmd_q.attn;
  assign tcal_stb = cmd_q.tcal;
  assign tcen_stb = cmd_q.tcen;
endmodule

// File: rtl/row_decode_checker.sv
module row_decode_checker
  import row_pkt_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       pkt_done,
  input logic       dev_hit,
  input logic       dev_bcast,
  input logic       refr_bump,
  input logic [8:0] refr_cnt,
  input row_cmd_t   cmd_q
);
  logic any_stb;
  assign any_stb = |cmd_q;

  assert_strobe_after_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    any_stb |-> $past(pkt_done));

  assert_frames_spaced_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done |=> !pkt_done);

  assert_nomatch_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_done && !dev_hit) |=> !any_stb);

  assert_act_alone_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_q.act |-> !(cmd_q.pre || cmd_q.refa || cmd_q.refp || cmd_q.rlx || cmd_q.tcal || cmd_q.tcen));

  assert_refr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    refr_bump |=> (refr_cnt == 9'($past(refr_cnt) + 9'd1)));

  assert_refr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !refr_bump |=> $stable(refr_cnt));

  assert_bcast_no_attn_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_done && dev_bcast) |=> !cmd_q.attn);

  assert_tcal_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_q.tcal, cmd_q.tcen}));
endmodule

bind row_packet_decoder row_decode_checker u_chk (
  .clk(clk), .rst_n(rst_n), .pkt_done(pkt_done), .dev_hit(dev_hit),
  .dev_bcast(dev_bcast), .refr_bump(refr_bump), .refr_cnt(refr_cnt), .cmd_q(cmd_q)
);

// File: tb/row_packet_decoder_test.sv
`timescale 1ns/1ps
module row_packet_decoder_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4:0] dev_id = 5'h0A;
  logic [2:0] row_early = '0, row_late = '0;
  logic act_stb, pre_stb, refa_stb, refp_stb, pdn_req, nap_req, napc_req;
  logic rlx_req, attn_req, tcal_stb, tcen_stb;
  logic [4:0] cmd_bank;
  logic [8:0] cmd_row;

  int checks = 0, fails = 0;
  logic [8:0] exp_refr = 9'h1FE;

  localparam logic [10:0] M_ACT = 11'h400, M_PRE = 11'h200, M_REFA = 11'h100,
    M_REFP = 11'h080, M_PDN = 11'h040, M_NAP = 11'h020, M_NAPC = 11'h010,
    M_RLX = 11'h008, M_ATTN = 11'h004, M_TCAL = 11'h002, M_TCEN = 11'h001;

  always #2 clk = ~clk;

  row_packet_decoder #(.REFR_RESET(9'h1FE)) uut (
    .clk(clk), .rst_n(rst_n), .dev_id(dev_id), .row_early(row_early), .row_late(row_late),
    .act_stb(act_stb), .pre_stb(pre_stb), .refa_stb(refa_stb), .refp_stb(refp_stb),
    .pdn_req(pdn_req), .nap_req(nap_req), .napc_req(napc_req), .rlx_req(rlx_req),
    .attn_req(attn_req), .tcal_stb(tcal_stb), .tcen_stb(tcen_stb),
    .cmd_bank(cmd_bank), .cmd_row(cmd_row)
  );

  function automatic logic [10:0] strobes();
    return {act_stb, pre_stb, refa_stb, refp_stb, pdn_req, nap_req, napc_req,
            rlx_req, attn_req, tcal_stb, tcen_stb};
  endfunction

  // Bench-side composer: three wire lanes, bit t = bit-time t.
  // Returned word: cycle k occupies [6k+5:6k] as {late w2,w1,w0, early w2,w1,w0}.
  function automatic logic [23:0] build(input logic [1:0] code, input logic [3:0] d,
                                        input logic [4:0] bank, input logic av,
                                        input logic [10:0] f);
    logic [7:0] la, lb, lc;
    logic [23:0] w;
    la = {f[2], f[5], f[8], f[10], bank[3], bank[0], d[2], code[1]};
    lb = {f[1], f[4], f[7], f[9],  bank[4], bank[1], d[1], code[0]};
    lc = {f[0], f[3], f[6], av,    1'b0,    bank[2], d[0], d[3]};
    for (int k = 0; k < 4; k++)
      w[6*k +: 6] = {la[2*k+1], lb[2*k+1], lc[2*k+1], la[2*k], lb[2*k], lc[2*k]};
    return w;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic drive(input logic [23:0] w);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      row_early = w[6*k +: 3];
      row_late  = w[6*k+3 +: 3];
    end
  endtask

  task automatic settle();
    @(negedge clk);
    row_early = '0;
    row_late  = '0;
  endtask

  task automatic send_check(input string req, input logic [23:0] w, input logic [10:0] exp);
    drive(w);
    settle();
    chk(req, "strobes", 32'(strobes()), 32'(exp));
    @(negedge clk);
    chk("R2", "strobe width", 32'(strobes()), 32'h0);
  endtask

  task automatic t_reset();
    chk("R11", "strobes", 32'(strobes()), 0);
    chk("R11", "bank", 32'(cmd_bank), 0);
    chk("R11", "row", 32'(cmd_row), 0);
  endtask

  task automatic t_activate();
    send_check("R4", build(2'b01, 4'hA, 5'h13, 1'b1, {2'b00, 9'h15A}), M_ACT | M_ATTN);
    chk("R4", "bank", 32'(cmd_bank), 32'h13);
    chk("R4", "row", 32'(cmd_row), 32'h15A);
    send_check("R9", build(2'b11, 4'h3, 5'h0C, 1'b1, {2'b00, 9'h0A5}), M_ACT);
    chk("R4", "bcast row", 32'(cmd_row), 32'h0A5);
  endtask

  task automatic t_match();
    send_check("R3", build(2'b10, 4'hA, 5'h01, 1'b1, 11'h011), 11'h0);
    send_check("R3", build(2'b01, 4'hB, 5'h01, 1'b1, 11'h011), 11'h0);
    chk("R3", "bank kept", 32'(cmd_bank), 32'h0C);
    dev_id = 5'h1A;
    send_check("R3", build(2'b10, 4'hA, 5'h02, 1'b0, 11'b11000000000), M_PRE | M_ATTN);
    dev_id = 5'h0A;
  endtask

  task automatic t_rowops();
    send_check("R5", build(2'b01, 4'hA, 5'h07, 1'b0, 11'b11000000000), M_PRE | M_ATTN);
    chk("R5", "bank", 32'(cmd_bank), 32'h07);
    send_check("R8", build(2'b01, 4'hA, 5'h04, 1'b0, 11'b11000111000), M_PRE | M_NAPC | M_RLX);
    send_check("R9", build(2'b11, 4'h0, 5'h00, 1'b0, 11'b00000010000), M_PDN);
    send_check("R8", build(2'b01, 4'hA, 5'h00, 1'b0, 11'b00000100000), M_NAP | M_ATTN);
    send_check("R7", build(2'b01, 4'hA, 5'h09, 1'b0, 11'b10101000000), M_REFP | M_ATTN);
    send_check("R10", build(2'b01, 4'hA, 5'h00, 1'b0, 11'b00000000001), M_TCAL);
    send_check("R10", build(2'b01, 4'hA, 5'h00, 1'b0, 11'b00000000010), M_TCEN);
    send_check("R10", build(2'b01, 4'hA, 5'h00, 1'b0, 11'b00000000000), 11'h0);
    send_check("R10", build(2'b01, 4'hA, 5'h00, 1'b0, 11'b00000000011), 11'h0);
  endtask

  task automatic refa(input logic [4:0] bank);
    send_check("R6", build(2'b01, 4'hA, bank, 1'b0, 11'b00011000000), M_REFA | M_ATTN);
    chk("R6", "refresh row", 32'(cmd_row), 32'(exp_refr));
    if (bank == 5'h1F) exp_refr = exp_refr + 9'd1;
  endtask

  task automatic t_refresh();
    refa(5'h05);
    refa(5'h1F);
    refa(5'h1F);
    refa(5'h00);
    chk("R6", "wrapped row", 32'(cmd_row), 32'h000);
  endtask

  task automatic t_framing();
    int seen = 0;
    @(negedge clk);
    row_early = 3'b000;
    row_late  = 3'b110;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      row_early = '0;
      row_late  = '0;
      if (strobes() != 0) seen++;
    end
    chk("R1", "late-only pulse", 32'(seen), 0);
    send_check("R1", build(2'b00, 4'h8, 5'h00, 1'b0, 11'h0), 11'h0);
  endtask

  task automatic t_back_to_back();
    logic [10:0] first;
    drive(build(2'b01, 4'hA, 5'h02, 1'b0, 11'b11000000000));
    drive(build(2'b01, 4'hA, 5'h00, 1'b0, 11'b00000000010));
    first = 11'h0;
    settle();
    chk("R1", "second of pair", 32'(strobes()), 32'(M_TCEN));
    chk("R1", "bank of pair", 32'(cmd_bank), 32'h00);
    drive(build(2'b01, 4'hA, 5'h06, 1'b0, 11'b11000000000));
    @(negedge clk);
    row_early = '0;
    row_late  = '0;
    first = strobes();
    chk("R2", "first of pair", 32'(first), 32'(M_PRE | M_ATTN));
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #800000;
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_activate();
    t_match();
    t_rowops();
    t_refresh();
    t_framing();
    t_back_to_back();
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule